// File: doc/BRIEF.md
# Fetch and Decode Timing Controller

This block is the hardwired sequencer at the heart of a single-accumulator processor. A sequence counter steps through timing slots, and each slot is decoded to a one-hot timing vector. The fixed early slots drive the shared data bus selector and the load, increment and memory-read strobes of the address register, program counter and instruction register. They move the program counter into the address register, fetch the instruction word while advancing the program counter, and then place the instruction's address field into the address register. The opcode field of the instruction register is decoded one-hot at all times. The addressing-mode bit is captured in a dedicated flip-flop.

In the fourth slot the controller sorts the instruction into one of four paths. These are a memory operand with one extra indirect read of the address register, a memory operand used directly, a register operation and an I/O operation. Register and I/O operations return the counter to slot zero at once, so the next fetch begins. Memory-operand instructions go on into the execute slots, where an external execute unit ends the instruction by asking for a counter clear. For register operations, the controller also passes on the single selected operation bit. It blanks this bit when the encoding is malformed.

Top module: `fetch_ctl`

## Requirements
- R1: While rst_ni is low, the counter is zero, t_o equals 16'h0001 and ind_o is 0.
- R2: Without a clear, the counter advances by one each clock and wraps from slot 15 to slot 0. t_o has exactly bit SC set.
- R3: d_o is one-hot, with bit ir_i[14:12] set.
- R4: In slot 0, bus_sel_o is 3'b010 (program counter) and ar_ld_o is the only strobe asserted.
- R5: In slot 1, bus_sel_o is 3'b111 (memory), and mem_rd_o, ir_ld_o and pc_inr_o are asserted while ar_ld_o is not.
- R6: In slot 2, bus_sel_o is 3'b101 (instruction register) and ar_ld_o is the only strobe. ind_o takes ir_i[15] at the end of slot 2 and holds it until the next slot 2.
- R7: In slot 3 with opcode field not 3'b111 and ind_o=1, mem_rd_o and ar_ld_o are asserted with bus_sel_o 3'b111, mref_o is 1, and slot 4 follows.
- R8: In slot 3 with opcode field not 3'b111 and ind_o=0, mref_o is 1, no strobe is asserted, bus_sel_o is 3'b000, and slot 4 follows.
- R9: In slot 3 with opcode field 3'b111 and ind_o=0, rref_o is 1 and slot 0 follows.
- R10: In slot 3 with opcode field 3'b111 and ind_o=1, iop_o is 1 and slot 0 follows.
- R11: rr_op_o equals ir_i[11:0] when rref_o is 1 and exactly one of those bits is set. In every other case it is zero, including a register operation with no bit or several bits set.
- R12: When sc_clr_i is high in slot 4 or later, the next slot is 0. In slots 0 to 3 the input is ignored.
- R13: In slots 4 to 15, no strobe is asserted and bus_sel_o is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | 16 | Instruction register contents |
| sc_clr_i | input | 1 | Counter clear requested by execute logic |
| t_o | output | 16 | One-hot timing slot |
| d_o | output | 8 | One-hot opcode decode |
| ind_o | output | 1 | Captured addressing-mode bit |
| bus_sel_o | output | 3 | Shared bus source select |
| ar_ld_o | output | 1 | Address register load |
| pc_inr_o | output | 1 | Program counter increment |
| ir_ld_o | output | 1 | Instruction register load |
| mem_rd_o | output | 1 | Memory read enable |
| mref_o | output | 1 | Memory-operand path flag |
| rref_o | output | 1 | Register-operation path flag |
| iop_o | output | 1 | I/O path flag |
| rr_op_o | output | 12 | Selected register operation bit |

## Verification
The bench builds the controller with its default parameters: a 4-bit counter, a 3-bit opcode and a 16-bit word. With these values, all sixteen timing slots and the wrap from slot 15 to slot 0 can be reached in one short run. All eight opcode decodes and both values of the mode bit can be exercised with a dozen instruction words. The same narrow fields make the malformed register-operation encodings, with no bit or two bits set, simple to build.

// File: rtl/fetch_ctl_pkg.sv
package fetch_ctl_pkg;
  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_AR   = 3'd1,
    BUS_PC   = 3'd2,
    BUS_DR   = 3'd3,
    BUS_AC   = 3'd4,
    BUS_IR   = 3'd5,
    BUS_TR   = 3'd6,
    BUS_MEM  = 3'd7
  } bus_src_e;

  typedef struct packed {
    logic mem_rd;
    logic ir_ld;
    logic ar_ld;
    logic pc_inr;
  } strobe_t;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int IN_W = 4,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel_i,
  output logic [OUT_N-1:0] dec_o
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_dec
    assign dec_o[k] = (sel_i == IN_W'(k));
  end
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int SC_W = 4,
  localparam int T_N = 1 << SC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [SC_W-1:0] sc_o,
  output logic [T_N-1:0]  t_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sc_q <= '0;
    else if (clr_i) sc_q <= '0;
    else            sc_q <= sc_q + 1'b1;
  end

  assign sc_o = sc_q;

  onehot_dec #(.IN_W(SC_W)) u_tdec (
    .sel_i (sc_q),
    .dec_o (t_o)
  );

  AST_SC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> sc_q == SC_W'($past(sc_q) + 1'b1)); // R2
  AST_SC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sc_q == '0); // R12
  AST_T_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(t_o) == 1); // R2
endmodule

// File: rtl/path_sel.sv
module path_sel #(
  parameter int ADDR_W = 12
) (
  input  logic              t3_i,
  input  logic              d_top_i,
  input  logic              ind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mref_o,
  output logic              rref_o,
  output logic              iop_o,
  output logic [ADDR_W-1:0] rr_op_o
);
  logic single_bit;

  assign single_bit = (addr_i != '0) && ((addr_i & (addr_i - 1'b1)) == '0);

  assign mref_o  = t3_i & ~d_top_i;
  assign rref_o  = t3_i & d_top_i & ~ind_i;
  assign iop_o   = t3_i & d_top_i & ind_i;
  assign rr_op_o = (rref_o && single_bit) ? addr_i : '0;

  always_comb begin
    AST_PATH_EXCL: assert ($onehot0({mref_o, rref_o, iop_o})); // R8
    AST_RR_SINGLE: assert (rr_op_o == '0 || $onehot(rr_op_o)); // R11
  end
endmodule

// File: rtl/fetch_ctl.sv
module fetch_ctl
  import fetch_ctl_pkg::*;
#(
  parameter int SC_W   = 4,
  parameter int OP_W   = 3,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  localparam int T_N       = 1 << SC_W,
  localparam int D_N       = 1 << OP_W,
  localparam int EXEC_SLOT = 4,
  localparam int MODE_BIT  = WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              sc_clr_i,
  output logic [T_N-1:0]    t_o,
  output logic [D_N-1:0]    d_o,
  output logic              ind_o,
  output logic [2:0]        bus_sel_o,
  output logic              ar_ld_o,
  output logic              pc_inr_o,
  output logic              ir_ld_o,
  output logic              mem_rd_o,
  output logic              mref_o,
  output logic              rref_o,
  output logic              iop_o,
  output logic [ADDR_W-1:0] rr_op_o
);
  logic [SC_W-1:0] sc;
  logic [T_N-1:0]  t;
  logic [D_N-1:0]  d;
  logic            sc_clr;
  logic            ind_q;
  logic            ext_clr_ok;
  bus_src_e        bus_sel;
  strobe_t         stb;

  // external clear is honoured only once the fetch phase is over
  assign ext_clr_ok = sc_clr_i && (sc >= SC_W'(EXEC_SLOT));
  assign sc_clr     = (t[3] & d[D_N-1]) | ext_clr_ok;

  seq_counter #(.SC_W(SC_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sc_clr),
    .sc_o   (sc),
    .t_o    (t)
  );

  onehot_dec #(.IN_W(OP_W)) u_odec (
    .sel_i (ir_i[MODE_BIT-1 -: OP_W]),
    .dec_o (d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ind_q <= 1'b0;
    else if (t[2]) ind_q <= ir_i[MODE_BIT];
  end

  path_sel #(.ADDR_W(ADDR_W)) u_path (
    .t3_i    (t[3]),
    .d_top_i (d[D_N-1]),
    .ind_i   (ind_q),
    .addr_i  (ir_i[ADDR_W-1:0]),
    .mref_o  (mref_o),
    .rref_o  (rref_o),
    .iop_o   (iop_o),
    .rr_op_o (rr_op_o)
  );

  always_comb begin
    bus_sel = BUS_NONE;
    stb     = '0;
    if (t[0]) begin
      bus_sel   = BUS_PC;
      stb.ar_ld = 1'b1;
    end else if (t[1]) begin
      bus_sel    = BUS_MEM;
      stb.mem_rd = 1'b1;
      stb.ir_ld  = 1'b1;
      stb.pc_inr = 1'b1;
    end else if (t[2]) begin
      bus_sel   = BUS_IR;
      stb.ar_ld = 1'b1;
    end else if (t[3] && !d[D_N-1] && ind_q) begin
      bus_sel    = BUS_MEM;
      stb.mem_rd = 1'b1;
      stb.ar_ld  = 1'b1;
    end
  end

  assign t_o       = t;
  assign d_o       = d;
  assign ind_o     = ind_q;
  assign bus_sel_o = bus_sel;
  assign ar_ld_o   = stb.ar_ld;
  assign pc_inr_o  = stb.pc_inr;
  assign ir_ld_o   = stb.ir_ld;
  assign mem_rd_o  = stb.mem_rd;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_o[2] |=> $stable(ind_o)); // R6
  AST_MODE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[2] |=> ind_o == $past(ir_i[MODE_BIT])); // R6
  AST_SHORT_PATH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rref_o || iop_o) |=> t_o[0]); // R9
  AST_MEM_PATH_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mref_o |=> t_o[EXEC_SLOT]); // R8
  AST_EARLY_CLR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o[0] || t_o[1] || t_o[2]) |=> !t_o[0]); // R12
  AST_READ_ON_MEM_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> bus_sel_o == 3'b111); // R5
  AST_FETCH_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inr_o |-> ir_ld_o); // R5
endmodule

// File: tb/fetch_ctl_test.sv
module fetch_ctl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ir_i = '0;
  logic        sc_clr_i = 1'b0;
  logic [15:0] t_o;
  logic [7:0]  d_o;
  logic        ind_o;
  logic [2:0]  bus_sel_o;
  logic        ar_ld_o, pc_inr_o, ir_ld_o, mem_rd_o;
  logic        mref_o, rref_o, iop_o;
  logic [11:0] rr_op_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fetch_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir_i), .sc_clr_i(sc_clr_i),
    .t_o(t_o), .d_o(d_o), .ind_o(ind_o), .bus_sel_o(bus_sel_o),
    .ar_ld_o(ar_ld_o), .pc_inr_o(pc_inr_o), .ir_ld_o(ir_ld_o), .mem_rd_o(mem_rd_o),
    .mref_o(mref_o), .rref_o(rref_o), .iop_o(iop_o), .rr_op_o(rr_op_o)
  );

  // {instr, {ind_read, mref, rref, iop}, rr_op}
  localparam logic [31:0] VEC [12] = '{
    {16'h0123, 4'b0100, 12'h000},
    {16'h9456, 4'b1100, 12'h000},
    {16'h2abc, 4'b0100, 12'h000},
    {16'hE00F, 4'b1100, 12'h000},
    {16'h7800, 4'b0010, 12'h800},
    {16'h7001, 4'b0010, 12'h001},
    {16'h7003, 4'b0010, 12'h000},
    {16'h7000, 4'b0010, 12'h000},
    {16'hF800, 4'b0001, 12'h000},
    {16'hF040, 4'b0001, 12'h000},
    {16'h4010, 4'b0100, 12'h000},
    {16'hB020, 4'b1100, 12'h000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic [3:0] strobes();
    return {mem_rd_o, ir_ld_o, ar_ld_o, pc_inr_o};
  endfunction

  // starts in slot 0, ends back in slot 0
  task automatic run_instr(input logic [15:0] ins, input logic [3:0] fl,
                           input logic [11:0] rr);
    string preq;
    preq = fl[1] ? "R9" : fl[0] ? "R10" : fl[3] ? "R7" : "R8";
    chk("R4 slot", 32'(t_o), 32'h1);
    chk("R4 bus/strobes", {25'd0, bus_sel_o, strobes()}, {25'd0, 3'b010, 4'b0010});
    ir_i = ins;
    tick;
    chk("R5 slot", 32'(t_o), 32'h2);
    chk("R5 bus/strobes", {25'd0, bus_sel_o, strobes()}, {25'd0, 3'b111, 4'b1101});
    tick;
    chk("R6 bus/strobes", {25'd0, bus_sel_o, strobes()}, {25'd0, 3'b101, 4'b0010});
    chk("R3 opcode", 32'(d_o), 32'(8'(1) << ins[14:12]));
    tick;
    chk("R6 mode bit", 32'(ind_o), 32'(ins[15]));
    chk(preq, {28'd0, mem_rd_o & ar_ld_o & (bus_sel_o == 3'b111), mref_o, rref_o, iop_o},
        {28'd0, fl});
    if (fl == 4'b0100)
      chk("R8 idle", {25'd0, bus_sel_o, strobes()}, 32'd0);
    chk("R11 rr op", 32'(rr_op_o), 32'(rr));
    tick;
    if (fl[2]) begin
      chk(preq, 32'(t_o), 32'h10);
      chk("R13 idle", {25'd0, bus_sel_o, strobes()}, 32'd0);
      sc_clr_i = 1'b1;
      tick;
      sc_clr_i = 1'b0;
      chk("R12 clear", 32'(t_o), 32'h1);
    end else begin
      chk(preq, 32'(t_o), 32'h1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 reset slot", 32'(t_o), 32'h1);
    chk("R1 reset mode", 32'(ind_o), 32'h0);
    tick;
    rst_ni = 1'b1;

    foreach (VEC[i]) run_instr(VEC[i][31:16], VEC[i][15:12], VEC[i][11:0]);

    // R12: clear held through fetch slots is ignored, honoured in slot 4
    sc_clr_i = 1'b1;
    ir_i = 16'h1111;
    tick; chk("R12 ignore T0", 32'(t_o), 32'h2);
    tick; chk("R12 ignore T1", 32'(t_o), 32'h4);
    tick; chk("R12 ignore T2", 32'(t_o), 32'h8);
    tick; chk("R12 ignore T3", 32'(t_o), 32'h10);
    tick; chk("R12 clear T4", 32'(t_o), 32'h1);
    sc_clr_i = 1'b0;

    // R2 / R13: run all slots and wrap
    ir_i = 16'h3000;
    for (int s = 1; s < 16; s++) begin
      tick;
      chk("R2 step", 32'(t_o), 32'(16'(1) << s));
      if (s >= 4) chk("R13 idle", {25'd0, bus_sel_o, strobes()}, 32'd0);
    end
    tick;
    chk("R2 wrap", 32'(t_o), 32'h1);

    // R1: asynchronous reset mid-instruction after an indirect capture
    ir_i = 16'h8abc;
    tick; tick; tick;
    chk("R6 mode set", 32'(ind_o), 32'h1);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async slot", 32'(t_o), 32'h1);
    chk("R1 async mode", 32'(ind_o), 32'h0);
    tick;
    rst_ni = 1'b1;
    run_instr(16'h7040, 4'b0010, 12'h040);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule